// File: doc/BRIEF.md
# Buffered UART Transmitter

This block is the transmit half of a serial port. It has a single holding buffer in front of a frame shifter. Software programs a small control register that enables the channel and chooses a parity mode. It then writes bytes into the buffer. At the next bit-rate tick the block moves the byte into the shifter. It then sends a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. Each bit lasts exactly one tick period.

Progress is reported through two read-only flags in the same register. The buffer-empty flag tells software that it may write the next byte. The frame-done flag tells it that the line has gone quiet after the last byte. The interrupt request follows the buffer-empty flag, but only once a written byte has actually been handed to the shifter. A byte that is pending when a stop bit ends goes out at once, with no idle bit time between the two frames.

Top module: `uart_tx_buffered`

## Requirements
- R1: While control bit 0 (enable) is 0, `txd` is high, no frame starts, the buffer is emptied, and data writes are dropped. Clearing bit 0 in the middle of a frame aborts it, and the line returns high on the next cycle.
- R2: The frame is one low start bit, then 8 data bits with bit 0 first, then one high stop bit. Each bit changes on a `bit_tick` edge and lasts one tick period. A buffered byte starts on the first tick after it was written.
- R3: When control bit 1 is set, a parity bit is sent between the last data bit and the stop bit. When it is clear, no parity bit is sent.
- R4: Control bit 2 selects the parity type. With 0, the parity bit is the XOR of the data bits (even parity). With 1, it is the inverse of that XOR (odd parity).
- R5: Status bit 4 (buffer empty) reads 1 after reset and while the block is disabled. A data write clears it. It sets again on the tick that moves the byte into the shifter.
- R6: `irq` is high only when the buffer is empty and at least one byte has been moved into the shifter since the block was last enabled. An enabled block that has never loaded a byte keeps `irq` low.
- R7: Status bit 5 (frame done) sets on the tick that ends a stop bit when no byte is pending. A cycle with `ctrl_rd` high clears it on the next cycle. Loading a new frame also clears it.
- R8: If a byte is pending when a stop bit ends, its start bit begins on that same tick, and status bit 5 stays 0 across the boundary.
- R9: A data write while the buffer is already full replaces the pending byte. Only the last byte written is sent.
- R10: Control bits 7, 6 and 3 read as 0, and writing them has no effect. Bits 2 to 0 read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| ctrl_wr | input | 1 | Write strobe for the control register |
| data_wr | input | 1 | Write strobe for the transmit buffer |
| ctrl_rd | input | 1 | Read strobe for the control register; clears frame done |
| wdata | input | 8 | Write data bus shared by both registers |
| ctrl_rdata | output | 8 | Control and status register contents |
| txd | output | 1 | Serial output line, idle high |
| irq | output | 1 | Buffer-empty interrupt request |

## Verification
The assertions assume that `ctrl_wr` and `data_wr` are never high in the same cycle, because both strobes share `wdata`. They also assume that `bit_tick` is a single-cycle pulse. The bench drives each strobe only through its own task. It produces ticks as one high cycle followed by three low cycles, and it never overlaps two write tasks. Under those conditions, the line can only change on a tick or on a control write, and the buffer-empty flag can only rise on a tick.

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered #(
  parameter int DW = 8,
  parameter int BW = (DW > 8) ? DW : 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          ctrl_wr,
  input  logic          data_wr,
  input  logic          ctrl_rd,
  input  logic [BW-1:0] wdata,
  output logic [7:0]    ctrl_rdata,
  output logic          txd,
  output logic          irq
);

  localparam int FW = DW + 2;
  localparam int CW = $clog2(FW + 1);

  logic          en_q, pen_q, podd_q;
  logic          full_q, busy_q, txd_q, done_q, armed_q;
  logic [DW-1:0] buf_q;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  logic en_nx, load, par;

  assign en_nx = ctrl_wr ? wdata[0] : en_q;
  assign load  = bit_tick && full_q && (!busy_q || cnt_q == '0);
  assign par   = (^buf_q) ^ podd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      full_q  <= 1'b0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
      buf_q   <= '0;
      sh_q    <= '1;
      cnt_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= wdata[0];
        pen_q  <= wdata[1];
        podd_q <= wdata[2];
      end
      if (!en_nx) begin
        full_q  <= 1'b0;
        busy_q  <= 1'b0;
        txd_q   <= 1'b1;
        done_q  <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        if (ctrl_rd) done_q <= 1'b0;
        if (load) begin
          busy_q  <= 1'b1;
          txd_q   <= 1'b0;
          sh_q    <= {1'b1, pen_q ? par : 1'b1, buf_q};
          cnt_q   <= pen_q ? CW'(FW) : CW'(FW - 1);
          armed_q <= 1'b1;
          done_q  <= 1'b0;
        end else if (bit_tick && busy_q) begin
          if (cnt_q == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            txd_q <= sh_q[0];
            sh_q  <= {1'b1, sh_q[FW-1:1]};
            cnt_q <= cnt_q - 1'b1;
          end
        end
        if (data_wr) begin
          full_q <= 1'b1;
          buf_q  <= wdata[DW-1:0];
        end else if (load) begin
          full_q <= 1'b0;
        end
      end
    end
  end

  assign txd        = txd_q;
  assign irq        = armed_q && !full_q;
  assign ctrl_rdata = {2'b00, done_q, !full_q, 1'b0, podd_q, pen_q, en_q};

  assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (txd && ctrl_rdata[4] && !irq));

  assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(bit_tick));

  assert_line_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_tick || ctrl_wr));

  assert_empty_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_rdata[4]) && en_q) |-> $past(bit_tick));

  assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && en_q && !ctrl_wr) |=> !ctrl_rdata[4]);

  assert_irq_needs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_rdata[4] && en_q));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !busy_q) |=> !ctrl_rdata[5]);

  assert_done_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[5] |-> txd);

endmodule

// File: tb/sim_uart_tx_buffered.sv
`timescale 1ns/1ps
module sim_uart_tx_buffered;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, ctrl_wr = 1'b0, data_wr = 1'b0, ctrl_rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       txd, irq;
  int         checks = 0, failures = 0;

  uart_tx_buffered u0 (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ctrl_wr(ctrl_wr),
    .data_wr(data_wr), .ctrl_rd(ctrl_rd), .wdata(wdata), .ctrl_rdata(ctrl_rdata),
    .txd(txd), .irq(irq));

  always #10 clk = ~clk;

  // {odd, parity_en, expected_parity_bit, data}
  localparam logic [10:0] VEC [0:5] = '{
    {3'b000, 8'h55}, {3'b010, 8'hA3}, {3'b111, 8'hA3},
    {3'b010, 8'h00}, {3'b111, 8'hFF}, {3'b000, 8'h80}};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clk1(input logic tk);
    bit_tick = tk;
    @(posedge clk); #2;
    bit_tick = 1'b0;
  endtask

  task automatic bit_next();
    clk1(0); clk1(0); clk1(0); clk1(1);
  endtask

  task automatic put_ctrl(input logic [7:0] v);
    ctrl_wr = 1'b1; wdata = v;
    @(posedge clk); #2;
    ctrl_wr = 1'b0;
  endtask

  task automatic put_data(input logic [7:0] v);
    data_wr = 1'b1; wdata = v;
    @(posedge clk); #2;
    data_wr = 1'b0;
  endtask

  task automatic read_ctrl();
    ctrl_rd = 1'b1;
    @(posedge clk); #2;
    ctrl_rd = 1'b0;
  endtask

  task automatic frame_body(input logic [7:0] d, input logic pe, input logic pb);
    for (int i = 0; i < 8; i++) begin
      bit_next();
      chk("R2", "data bit", txd, d[i]);
    end
    if (pe) begin
      bit_next();
      chk("R3", "parity bit", txd, pb);
    end
    bit_next();
    chk("R2", "stop bit", txd, 1);
    chk("R7", "done during stop", ctrl_rdata[5], 0);
  endtask

  task automatic frame_end();
    bit_next();
    chk("R2", "line after stop", txd, 1);
    chk("R7", "done after stop", ctrl_rdata[5], 1);
    chk("R6", "irq after frame", irq, 1);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk("R5", "reset status", ctrl_rdata, 8'h10);
    chk("R1", "reset line", txd, 1);
    chk("R6", "reset irq", irq, 0);

    put_data(8'h3C);
    chk("R1", "write while off", ctrl_rdata[4], 1);
    clk1(1);
    chk("R1", "line while off", txd, 1);

    put_ctrl(8'hFF);
    chk("R10", "reserved readback", ctrl_rdata, 8'h17);
    chk("R6", "irq before first load", irq, 0);
    clk1(1);
    chk("R1", "dropped byte not sent", txd, 1);
    put_ctrl(8'hC9);
    chk("R10", "reserved ignored", ctrl_rdata, 8'h11);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] d;
      logic od, pe, pb;
      {od, pe, pb, d} = VEC[v];
      chk("R4", "table parity", pb, pe ? ((^d) ^ od) : 1'b0);
      put_ctrl({5'b0, od, pe, 1'b1});
      put_data(d);
      chk("R5", "empty cleared by write", ctrl_rdata[4], 0);
      chk("R6", "irq low while full", irq, 0);
      clk1(1);
      chk("R2", "start bit", txd, 0);
      chk("R5", "empty after load", ctrl_rdata[4], 1);
      frame_body(d, pe, pb);
      frame_end();
      read_ctrl();
      chk("R7", "done cleared by read", ctrl_rdata[5], 0);
    end

    put_ctrl(8'h01);
    put_data(8'h11);
    put_data(8'hE7);
    clk1(1);
    chk("R9", "overwrite start", txd, 0);
    frame_body(8'hE7, 1'b0, 1'b0);
    frame_end();

    put_data(8'h5A);
    clk1(1);
    chk("R7", "done cleared by new frame", ctrl_rdata[5], 0);
    put_data(8'hC3);
    frame_body(8'h5A, 1'b0, 1'b0);
    bit_next();
    chk("R8", "back-to-back start", txd, 0);
    chk("R8", "no done between frames", ctrl_rdata[5], 0);
    frame_body(8'hC3, 1'b0, 1'b0);
    frame_end();
    read_ctrl();

    put_data(8'hF0);
    clk1(1);
    chk("R2", "start before abort", txd, 0);
    put_ctrl(8'h00);
    chk("R1", "abort line high", txd, 1);
    chk("R1", "abort status", ctrl_rdata, 8'h10);
    chk("R6", "abort irq", irq, 0);
    put_ctrl(8'h01);
    chk("R6", "re-enable irq", irq, 0);
    clk1(1);
    chk("R1", "no frame after abort", txd, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule